// File: doc/BRIEF.md
# Outbound Endpoint Address Translator

This block turns local bus addresses issued on the endpoint side into 64-bit PCI addresses for outbound transfers. It holds a parameterised set of translation regions. Each region carries a valid flag, a 64-bit PCI base and a stored pass-through count. A local address picks its region through an index field that sits just above the region window. The translated address takes its upper bits from the region's PCI base and its low N bits from the local address. N is the region's pass-through count, which the block always limits to the range from 8 to the window width.

A separate combinational helper computes the right pass-through count for a mapping. It takes a PCI base and a byte count, finds how many low address bits change between the first and last byte of that range, and clamps the result. Software programs the regions through a single-cycle write port. It can use the helper output directly as the stored count field.

Top module: `obx_ob_translator`

## Requirements
- R1: After reset every region is invalid and out_valid, out_err and out_addr are all zero.
- R2: A write selects region wr_addr[3:2] and register wr_addr[1:0]. Register 0: bits 5:0 hold the count field, bits 31:8 hold PCI base bits 31:8, and bits 7:6 are discarded. Register 1: PCI base bits 63:32. Register 2: bit 0 is the valid flag. Register 3 writes change nothing.
- R3: A translation uses the region named by in_addr[21:20].
- R4: For a valid region, out_addr equals the PCI base with its low N bits cleared, OR-ed with the low N bits of in_addr.
- R5: N is the stored field plus one, raised to 8 when smaller and lowered to 20 when larger.
- R6: out_valid rises exactly one clock after a cycle with in_valid high and a valid region, and falls when no such request preceded it.
- R7: A request to an invalid region sets out_err for one clock one cycle later, with out_valid low and out_addr zero. out_addr is zero whenever out_valid is low.
- R8: calc_nbits equals the 1-based index of the highest set bit of base XOR (base+size-1), clamped to [8, 20]. A size of 0 is treated as 1, and the sum wraps modulo 2^64.
- R9: calc_field equals calc_nbits minus one, ready to be written into register 0 bits 5:0.
- R10: out_addr bits 7:0 always come from in_addr, whatever base bits 7:0 were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Region index (3:2) and register select (1:0) |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Local address request strobe |
| in_addr | input | 32 | Local address |
| out_valid | output | 1 | Translated address valid |
| out_err | output | 1 | Request hit an invalid region |
| out_addr | output | 64 | Translated PCI address |
| calc_base | input | 64 | Helper: PCI base of the mapping |
| calc_size | input | 64 | Helper: mapping size in bytes |
| calc_nbits | output | 6 | Helper: clamped pass-through count |
| calc_field | output | 6 | Helper: count minus one |

## Verification
The bench builds the block with its default parameters: four regions, a 32-bit local address, a 20-bit window and an 8-bit floor. These values let every region be reached through in_addr[21:20]. They also put both clamp limits within reach of stored fields 2 and 40, and of helper ranges that either fit in one byte or cross bit 20. The helper is exercised with aligned bases, an unaligned base where the size alone would give too small a count, a zero size, and a range that ends at the top of the 64-bit space.

// File: rtl/obx_pkg.sv
package obx_pkg;
   localparam int FIELD_W   = 6;
   localparam int BASE_LSB  = 8;
   localparam int CNT_W     = 7;

   typedef struct packed {
      logic              valid;
      logic [FIELD_W-1:0] nfield;
      logic [31:0]       base_hi;
      logic [31-BASE_LSB:0] base_lo;
   } obx_region_t;

   function automatic logic [CNT_W-1:0] obx_clamp(
      input logic [CNT_W-1:0] raw,
      input logic [CNT_W-1:0] lo,
      input logic [CNT_W-1:0] hi);
      logic [CNT_W-1:0] r;
      r = raw;
      if (r < lo) r = lo;
      if (r > hi) r = hi;
      return r;
   endfunction
endpackage

// File: rtl/obx_passbits.sv
module obx_passbits
   import obx_pkg::*;
#(
   parameter int MIN_BITS = 8,
   parameter int MAX_BITS = 20
) (
   input  logic [63:0]        base_i,
   input  logic [63:0]        size_i,
   output logic [FIELD_W-1:0] nbits_o,
   output logic [FIELD_W-1:0] field_o
);
   localparam logic [CNT_W-1:0] LO_N = CNT_W'(MIN_BITS);
   localparam logic [CNT_W-1:0] HI_N = CNT_W'(MAX_BITS);

   logic [63:0]      eff_size;
   logic [63:0]      last_byte;
   logic [63:0]      diff;
   logic [CNT_W-1:0] top_bit;
   logic [CNT_W-1:0] clamped;

   always_comb begin
      eff_size  = (size_i == 64'd0) ? 64'd1 : size_i;
      last_byte = base_i + eff_size - 64'd1;
      diff      = base_i ^ last_byte;
      top_bit   = '0;
      for (int b = 0; b < 64; b++) begin
         if (diff[b]) top_bit = CNT_W'(b + 1);
      end
      clamped = obx_clamp(top_bit, LO_N, HI_N);
   end

   assign nbits_o = clamped[FIELD_W-1:0];
   assign field_o = clamped[FIELD_W-1:0] - FIELD_W'(1);

   always_comb begin
      AST_CALC_RANGE: assert (clamped >= LO_N && clamped <= HI_N); // R8
   end
endmodule

// File: rtl/obx_regfile.sv
module obx_regfile
   import obx_pkg::*;
#(
   parameter int NUM_REGIONS = 4,
   localparam int IDX_W = $clog2(NUM_REGIONS),
   localparam int REG_AW = IDX_W + 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [REG_AW-1:0]             wr_addr,
   input  logic [31:0]                   wr_data,
   output obx_region_t [NUM_REGIONS-1:0] regs_o
);
   logic [IDX_W-1:0] wr_idx;
   logic [1:0]       wr_sel;

   assign wr_idx = wr_addr[REG_AW-1:2];
   assign wr_sel = wr_addr[1:0];

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      obx_region_t r_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r_q <= '0;
         end else if (wr_en && wr_idx == IDX_W'(r)) begin
            case (wr_sel)
               2'd0: begin
                  r_q.nfield  <= wr_data[FIELD_W-1:0];
                  r_q.base_lo <= wr_data[31:BASE_LSB];
               end
               2'd1:    r_q.base_hi <= wr_data;
               2'd2:    r_q.valid   <= wr_data[0];
               default: r_q         <= r_q;
            endcase
         end
      end
      assign regs_o[r] = r_q;
   end

   AST_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=> regs_o[$past(wr_idx)].base_hi == $past(wr_data)) // R2
      else $error("high base write lost");
   AST_SEL3_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3) |=> $stable(regs_o)) // R2
      else $error("register 3 write changed state");
endmodule

// File: rtl/obx_xlate.sv
module obx_xlate
   import obx_pkg::*;
#(
   parameter int NUM_REGIONS = 4,
   parameter int LADDR_W     = 32,
   parameter int WIN_BITS    = 20,
   parameter int MIN_BITS    = 8,
   localparam int IDX_W = $clog2(NUM_REGIONS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  obx_region_t [NUM_REGIONS-1:0] regs_i,
   input  logic                          in_valid,
   input  logic [LADDR_W-1:0]            in_addr,
   output logic                          out_valid,
   output logic                          out_err,
   output logic [63:0]                   out_addr
);
   localparam logic [CNT_W-1:0] LO_N = CNT_W'(MIN_BITS);
   localparam logic [CNT_W-1:0] HI_N = CNT_W'(WIN_BITS);

   logic [IDX_W-1:0] idx;
   obx_region_t      sel;
   logic [CNT_W-1:0] n_eff;
   logic [63:0]      mask;
   logic [63:0]      base_full;
   logic [63:0]      local_ext;
   logic [63:0]      next_addr;
   logic             hit;

   assign idx       = in_addr[WIN_BITS +: IDX_W];
   assign sel       = regs_i[idx];
   assign n_eff     = obx_clamp({1'b0, sel.nfield} + CNT_W'(1), LO_N, HI_N);
   assign base_full = {sel.base_hi, sel.base_lo, {BASE_LSB{1'b0}}};
   assign local_ext = {{(64-LADDR_W){1'b0}}, in_addr};

   for (genvar b = 0; b < 64; b++) begin : g_mask
      assign mask[b] = (n_eff > CNT_W'(b));
   end

   assign next_addr = (base_full & ~mask) | (local_ext & mask);
   assign hit       = in_valid && sel.valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_addr  <= '0;
      end else begin
         out_valid <= hit;
         out_err   <= in_valid && !sel.valid;
         out_addr  <= hit ? next_addr : 64'd0;
      end
   end

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid)) // R6
      else $error("out_valid without request");
   AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sel.valid) |=> (out_err && !out_valid)) // R7
      else $error("invalid region not flagged");
   AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> out_addr == 64'd0) // R7
      else $error("address not zero while idle");
   AST_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_addr[7:0] == $past(in_addr[7:0])) // R10
      else $error("low byte not passed through");
endmodule

// File: rtl/obx_ob_translator.sv
module obx_ob_translator
   import obx_pkg::*;
#(
   parameter int NUM_REGIONS = 4,
   parameter int LADDR_W     = 32,
   parameter int WIN_BITS    = 20,
   parameter int MIN_BITS    = 8,
   localparam int IDX_W  = $clog2(NUM_REGIONS),
   localparam int REG_AW = IDX_W + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_AW-1:0]   wr_addr,
   input  logic [31:0]         wr_data,
   input  logic                in_valid,
   input  logic [LADDR_W-1:0]  in_addr,
   output logic                out_valid,
   output logic                out_err,
   output logic [63:0]         out_addr,
   input  logic [63:0]         calc_base,
   input  logic [63:0]         calc_size,
   output logic [FIELD_W-1:0]  calc_nbits,
   output logic [FIELD_W-1:0]  calc_field
);
   if (NUM_REGIONS < 2 || (1 << IDX_W) != NUM_REGIONS) begin : g_chk_regions
      $error("NUM_REGIONS must be a power of two, at least 2");
   end
   if (MIN_BITS != BASE_LSB) begin : g_chk_min
      $error("MIN_BITS must equal the stored base low bit position");
   end
   if (WIN_BITS < MIN_BITS || WIN_BITS > 32) begin : g_chk_win
      $error("WIN_BITS must lie between MIN_BITS and 32");
   end
   if (LADDR_W < WIN_BITS + IDX_W || LADDR_W >= 64) begin : g_chk_laddr
      $error("LADDR_W must hold window and index and stay below 64");
   end

   obx_region_t [NUM_REGIONS-1:0] regs;

   obx_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .regs_o  (regs)
   );

   obx_xlate #(
      .NUM_REGIONS (NUM_REGIONS),
      .LADDR_W     (LADDR_W),
      .WIN_BITS    (WIN_BITS),
      .MIN_BITS    (MIN_BITS)
   ) u_xlate (
      .clk       (clk),
      .rst_n     (rst_n),
      .regs_i    (regs),
      .in_valid  (in_valid),
      .in_addr   (in_addr),
      .out_valid (out_valid),
      .out_err   (out_err),
      .out_addr  (out_addr)
   );

   obx_passbits #(.MIN_BITS(MIN_BITS), .MAX_BITS(WIN_BITS)) u_calc (
      .base_i  (calc_base),
      .size_i  (calc_size),
      .nbits_o (calc_nbits),
      .field_o (calc_field)
   );

   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_err)) // R7
      else $error("valid and error together");
endmodule

// File: tb/sim_obx_ob_translator.sv
module sim_obx_ob_translator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_addr = '0;
   logic        out_valid, out_err;
   logic [63:0] out_addr;
   logic [63:0] calc_base = '0, calc_size = '0;
   logic [5:0]  calc_nbits, calc_field;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   obx_ob_translator u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid), .out_err(out_err),
      .out_addr(out_addr), .calc_base(calc_base), .calc_size(calc_size),
      .calc_nbits(calc_nbits), .calc_field(calc_field));

   // helper vectors: {base, size, expected count}
   localparam int NV = 11;
   localparam logic [191:0] VEC [NV] = '{
      {64'h0, 64'h1, 64'd8},
      {64'h0, 64'h0, 64'd8},
      {64'h1000, 64'h1000, 64'd12},
      {64'h1800, 64'h1000, 64'd14},
      {64'h100, 64'h100, 64'd8},
      {64'h0, 64'h100000, 64'd20},
      {64'hFFF00, 64'h200, 64'd20},
      {64'h12345600, 64'h80, 64'd8},
      {64'h1_0000_0000, 64'h400, 64'd10},
      {64'h3F000, 64'h2000, 64'd19},
      {64'hFFFF_FFFF_FFFF_FF00, 64'h100, 64'd8}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_xlate(input logic [63:0] base, input int field,
                                             input logic [31:0] la);
      int n;
      logic [63:0] m;
      n = field + 1;
      if (n < 8) n = 8;
      if (n > 20) n = 20;
      m = (64'd1 << n) - 64'd1;
      return ((base & ~64'hFF) & ~m) | ({32'd0, la} & m);
   endfunction

   task automatic wr(input logic [1:0] reg_idx, input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = {reg_idx, sel}; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic req(input logic [31:0] a);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
      check("R1 out_err after reset", {63'd0, out_err}, 64'd0);
      check("R1 out_addr after reset", out_addr, 64'd0);
      req(32'h0000_1234);
      check("R1 region0 invalid after reset", {62'd0, out_err, out_valid}, 64'd2);

      // helper table, R8 / R9
      for (int i = 0; i < NV; i++) begin
         calc_base = VEC[i][191:128];
         calc_size = VEC[i][127:64];
         #1;
         check($sformatf("R8 count vec %0d", i), {58'd0, calc_nbits}, VEC[i][63:0]);
         check($sformatf("R9 field vec %0d", i), {58'd0, calc_field}, VEC[i][63:0] - 64'd1);
      end

      // region 0: field 11 (N=12), base bits 7:6 written as ones
      wr(2'd0, 2'd0, 32'hCDE1_23CB);
      wr(2'd0, 2'd1, 32'h0000_00AB);
      wr(2'd0, 2'd2, 32'h1);
      req(32'h0000_5A5A);
      check("R4 region0 translate", out_addr, 64'h0000_00AB_CDE1_2A5A);
      check("R10 base bits 7:6 ignored", out_addr, ref_xlate(64'hAB_CDE1_23C0, 11, 32'h5A5A));
      check("R6 valid one cycle later", {63'd0, out_valid}, 64'd1);
      @(negedge clk);
      check("R6 valid drops", {63'd0, out_valid}, 64'd0);
      check("R7 zero while idle", out_addr, 64'd0);

      // region 1: field 2 -> N=8
      wr(2'd1, 2'd0, 32'h8765_4302);
      wr(2'd1, 2'd1, 32'h0000_0001);
      wr(2'd1, 2'd2, 32'h1);
      req(32'h0010_00EE);
      check("R5 low clamp", out_addr, 64'h0000_0001_8765_43EE);

      // region 2: field 40 -> N=20
      wr(2'd2, 2'd0, 32'hBEE0_0028);
      wr(2'd2, 2'd1, 32'h0000_DEAD);
      wr(2'd2, 2'd2, 32'h1);
      req(32'h0023_4567);
      check("R5 high clamp", out_addr, 64'h0000_DEAD_BEE3_4567);

      // region 3 before enabling -> error, then with helper field 13
      wr(2'd3, 2'd0, 32'h0000_180D);
      req(32'h0030_1234);
      check("R7 invalid region error", {62'd0, out_err, out_valid}, 64'd2);
      check("R7 invalid region addr", out_addr, 64'd0);
      wr(2'd3, 2'd2, 32'h1);
      req(32'h0030_1234);
      check("R3 region3 select", out_addr, ref_xlate(64'h1800, 13, 32'h0030_1234));

      // register 3 writes ignored
      wr(2'd0, 2'd3, 32'hFFFF_FFFF);
      req(32'h0000_5A5A);
      check("R2 reg3 write ignored", out_addr, 64'h0000_00AB_CDE1_2A5A);

      // high base write alone
      wr(2'd1, 2'd1, 32'h0000_0077);
      req(32'h0010_0011);
      check("R2 high base update", out_addr, 64'h0000_0077_8765_4311);

      // disable region 1
      wr(2'd1, 2'd2, 32'h0);
      req(32'h0010_0011);
      check("R7 disabled region", {62'd0, out_err, out_valid}, 64'd2);
      @(negedge clk);
      check("R7 error lasts one cycle", {63'd0, out_err}, 64'd0);

      // back-to-back requests
      @(negedge clk);
      in_valid = 1'b1; in_addr = 32'h0023_0001;
      @(negedge clk);
      check("R6 back-to-back first", out_addr, 64'h0000_DEAD_BEE3_0001);
      in_addr = 32'h0000_0F0F;
      @(negedge clk);
      in_valid = 1'b0;
      check("R3 back-to-back second", out_addr, 64'h0000_00AB_CDE1_2F0F);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule